// File: doc/BRIEF.md
# ADC Result Window Monitor

This block watches one of twelve analog-to-digital conversion result channels and compares each fresh result on that channel against a programmed threshold. The comparison is either "at or above" or "at or below" the threshold. Every comparison that meets the condition advances a hit counter. When the counter shows that the programmed number of matching comparisons has been reached, the block emits a one-cycle interrupt pulse and starts counting again for the next decision.

Software sets up the monitor through a small word-addressed register port with two registers. The control register holds the channel select, the required hit count, the condition select and an enable. The threshold register holds the compare value. The converter provides all twelve results as one flat vector, along with one completion strobe per channel. The monitor only compares and counts. It does not schedule conversions and does not route the interrupt.

Top module: `adc_win_mon`

## Requirements
- R1: After reset, both registers read as zero, the hit count is zero and `irq` is low. Register bits with no assigned field always read as zero.
- R2: The control register is at word address 0. Its fields are: channel select in bits [3:0], hit-count limit N in bits [7:4], condition select in bit 8 and enable in bit 12. The threshold register is at word address 1 and holds a 12-bit unsigned value in bits [11:0]. Any other address reads as zero.
- R3: Channel select codes 0 to 11 choose channel k. Channel k's result is `res_flat[12k+11:12k]` and its completion strobe is `res_done[k]`.
- R4: A comparison takes place only in a cycle where the selected channel's strobe is high. Strobes on other channels cause no comparison, whatever their result values are.
- R5: When the condition select is 0, a comparison is a hit if the result is greater than or equal to the threshold.
- R6: When the condition select is 1, a comparison is a hit if the result is less than or equal to the threshold.
- R7: With limit N, the (N+1)-th hit raises `irq` for exactly one cycle. The pulse appears in the cycle after the clock edge that sampled the strobe. N=0 fires on every hit.
- R8: A comparison that is not a hit leaves the hit count unchanged.
- R9: After an interrupt, the hit count restarts from zero, so the next interrupt needs another N+1 hits.
- R10: While enable is 0, no comparison counts and no interrupt fires. Clearing enable also discards the hits accumulated so far.
- R11: While a reserved channel code (12 to 15) is selected, no comparisons take place and the hit count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_flat | input | 144 | Twelve 12-bit conversion results; channel k is in bits [12k+11:12k] |
| res_done | input | 12 | Per-channel completion strobes, one cycle wide |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write enable, qualified by `bus_sel` |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | One-cycle decision interrupt |

## Verification
The bench checks that results exactly equal to the threshold count as hits under both conditions, since an off-by-one there would use a strict comparison. It interleaves misses with hits: a design that reset the counter on a miss would never fire, and one that counted misses would fire early. It also reaches the limit twice in a row and disables the monitor partway through a count, which exposes a counter that is not cleared. With a reserved channel selected it strobes every channel; a design that wrapped the select code onto a real channel would count those strobes and fire early once a real channel is selected again.

// File: rtl/adc_win_mon.sv
module adc_win_mon #(
  parameter int NCH = 12,
  parameter int RW  = 12,
  parameter int DW  = 32,
  parameter int AW  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*RW-1:0] res_flat,
  input  logic [NCH-1:0]    res_done,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq
);

  localparam int SEL_W   = 4;
  localparam int CNT_W   = 4;
  localparam int SEL_LSB = 0;
  localparam int CNT_LSB = 4;
  localparam int LE_BIT  = 8;
  localparam int EN_BIT  = 12;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_THR  = AW'(1);

  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] lim_q, hits_q;
  logic             le_q, en_q, irq_q;
  logic [RW-1:0]    thr_q, sel_res;
  logic             sel_done, chan_ok, hit, fire;

  wire ctrl_wr = bus_sel && bus_we && (bus_addr == A_CTRL);
  wire thr_wr  = bus_sel && bus_we && (bus_addr == A_THR);

  always_comb begin
    sel_res  = '0;
    sel_done = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (int'(sel_q) == i) begin
        sel_res  = res_flat[i*RW +: RW];
        sel_done = res_done[i];
      end
    end
  end

  assign chan_ok = int'(sel_q) < NCH;
  assign hit  = en_q && chan_ok && sel_done &&
                (le_q ? (sel_res <= thr_q) : (sel_res >= thr_q));
  assign fire = hit && (hits_q >= lim_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      lim_q <= '0;
      le_q  <= 1'b0;
      en_q  <= 1'b0;
      thr_q <= '0;
    end else begin
      if (ctrl_wr) begin
        sel_q <= bus_wdata[SEL_LSB +: SEL_W];
        lim_q <= bus_wdata[CNT_LSB +: CNT_W];
        le_q  <= bus_wdata[LE_BIT];
        en_q  <= bus_wdata[EN_BIT];
      end
      if (thr_wr) thr_q <= bus_wdata[RW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hits_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= fire;
      if (!en_q || fire) hits_q <= '0;
      else if (hit)      hits_q <= hits_q + 1'b1;
    end
  end

  assign irq = irq_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL) begin
      bus_rdata[SEL_LSB +: SEL_W] = sel_q;
      bus_rdata[CNT_LSB +: CNT_W] = lim_q;
      bus_rdata[LE_BIT]           = le_q;
      bus_rdata[EN_BIT]           = en_q;
    end else if (bus_addr == A_THR) begin
      bus_rdata[RW-1:0] = thr_q;
    end
  end

  // R10
  en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (hits_q == '0));

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(en_q) && $past(chan_ok) && $past(|res_done)));

  // R11
  rsv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !chan_ok && !ctrl_wr) |=> $stable(hits_q));

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hits_q != $past(hits_q)) |->
      (hits_q == '0 || hits_q == $past(hits_q) + 1'b1));

  // R10
  idle_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !irq);

endmodule

// File: tb/test_adc_win_mon.sv
module test_adc_win_mon;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [143:0] res_flat = '0;
  logic [11:0]  res_done = '0;
  logic         bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         irq;
  int checks = 0, errors = 0;

  adc_win_mon i_adc_win_mon (
    .clk(clk), .rst_n(rst_n), .res_flat(res_flat), .res_done(res_done),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(string req, logic [1:0] a, logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1 chk(req, bus_rdata, exp);
  endtask

  function automatic logic [31:0] ctrl(int sel, int n, bit le, bit en);
    return 32'(sel) | (32'(n) << 4) | (32'(le) << 8) | (32'(en) << 12);
  endfunction

  task automatic conv(logic [11:0] mask, int ch, logic [11:0] val, output logic got);
    @(negedge clk);
    res_flat[ch*12 +: 12] = val;
    res_done = mask;
    @(posedge clk);
    #1 got = irq;
    @(negedge clk);
    res_done = '0;
  endtask

  task automatic hit_expect(string req, int ch, logic [11:0] val, logic exp);
    logic g;
    conv(12'(1) << ch, ch, val, g);
    chk(req, 32'(g), 32'(exp));
  endtask

  task automatic t_reset;
    rd("R1 ctrl", 2'd0, 32'h0);
    rd("R1 thr", 2'd1, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_regs;
    wr(2'd0, 32'hFFFF_FFFF);
    rd("R2 ctrl mask", 2'd0, 32'h0000_11FF);
    wr(2'd1, 32'hFFFF_FFFF);
    rd("R2 thr mask", 2'd1, 32'h0000_0FFF);
    rd("R2 unused addr", 2'd2, 32'h0);
    wr(2'd0, 32'h0);
  endtask

  task automatic t_ge;
    wr(2'd1, 32'd100);
    wr(2'd0, ctrl(3, 0, 1'b0, 1'b1));
    hit_expect("R5 equal", 3, 12'd100, 1'b1);
    hit_expect("R5 below", 3, 12'd99, 1'b0);
    hit_expect("R5 above", 3, 12'd101, 1'b1);
  endtask

  task automatic t_le;
    wr(2'd0, ctrl(3, 0, 1'b1, 1'b1));
    hit_expect("R6 equal", 3, 12'd100, 1'b1);
    hit_expect("R6 above", 3, 12'd101, 1'b0);
    hit_expect("R6 zero", 3, 12'd0, 1'b1);
  endtask

  task automatic t_other_chan;
    logic g;
    for (int k = 0; k < 12; k++) res_flat[k*12 +: 12] = 12'd50;
    wr(2'd0, ctrl(3, 0, 1'b1, 1'b1));
    conv(12'(1) << 5, 5, 12'd50, g);
    chk("R4 foreign strobe", 32'(g), 32'h0);
    conv(12'hFFF & ~(12'(1) << 3), 7, 12'd50, g);
    chk("R4 other strobes", 32'(g), 32'h0);
    wr(2'd0, ctrl(11, 0, 1'b1, 1'b1));
    hit_expect("R3 channel 11", 11, 12'd7, 1'b1);
    res_flat[11*12 +: 12] = 12'd200;
    hit_expect("R3 channel 11 miss", 11, 12'd200, 1'b0);
  endtask

  task automatic t_count;
    logic g;
    wr(2'd1, 32'd100);
    wr(2'd0, ctrl(2, 3, 1'b0, 1'b1));
    hit_expect("R8 hit1", 2, 12'd150, 1'b0);
    hit_expect("R8 miss", 2, 12'd10, 1'b0);
    hit_expect("R8 hit2", 2, 12'd150, 1'b0);
    hit_expect("R8 miss", 2, 12'd10, 1'b0);
    hit_expect("R8 hit3", 2, 12'd150, 1'b0);
    hit_expect("R7 hit4 fires", 2, 12'd150, 1'b1);
    @(posedge clk); #1 chk("R7 one cycle", 32'(irq), 32'h0);
    for (int i = 0; i < 3; i++) hit_expect("R9 restart", 2, 12'd150, 1'b0);
    hit_expect("R9 refire", 2, 12'd150, 1'b1);
  endtask

  task automatic t_disable;
    hit_expect("R10 pre hit1", 2, 12'd150, 1'b0);
    hit_expect("R10 pre hit2", 2, 12'd150, 1'b0);
    wr(2'd0, ctrl(2, 3, 1'b0, 1'b0));
    for (int i = 0; i < 5; i++) hit_expect("R10 disabled", 2, 12'd150, 1'b0);
    wr(2'd0, ctrl(2, 3, 1'b0, 1'b1));
    for (int i = 0; i < 3; i++) hit_expect("R10 cleared", 2, 12'd150, 1'b0);
    hit_expect("R10 fourth", 2, 12'd150, 1'b1);
  endtask

  task automatic t_reserved;
    logic g;
    for (int k = 0; k < 12; k++) res_flat[k*12 +: 12] = 12'd500;
    wr(2'd0, ctrl(12, 1, 1'b0, 1'b1));
    for (int i = 0; i < 3; i++) begin
      conv(12'hFFF, 0, 12'd500, g);
      chk("R11 reserved", 32'(g), 32'h0);
    end
    wr(2'd0, ctrl(0, 1, 1'b0, 1'b1));
    hit_expect("R11 no carry", 0, 12'd500, 1'b0);
    hit_expect("R11 second", 0, 12'd500, 1'b1);
    wr(2'd0, ctrl(15, 0, 1'b0, 1'b1));
    conv(12'hFFF, 0, 12'd500, g);
    chk("R11 code 15", 32'(g), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_ge();
    t_le();
    t_other_chan();
    t_count();
    t_disable();
    t_reserved();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule